// File: doc/BRIEF.md
# Vector Compress Unit

This block packs the elements of a vector register group that are selected by a mask. Every source element whose mask bit is set is copied to the next free destination slot. Slots are filled in ascending order from element 0, so the selected elements keep their relative order. Destination slots past the packed count keep the contents the destination group held before the operation.

The selector always comes from an explicit one-register mask operand. The operation is never masked itself. Register numbers, the starting element index, the element width and the group size arrive with a one-cycle `start` pulse. On that edge the block checks the register layout. A legal request then examines one source element per clock. A request that breaks a layout rule is rejected at once, and the destination is left untouched. Reading and writing the register file, and decoding the instruction, belong to the surrounding pipeline.

A four-state machine drives the block. ST_IDLE waits for `start`. From ST_IDLE, a legal start with a nonzero element count goes to ST_SCAN. A legal start with a zero count goes to ST_FINISH. An illegal start goes to ST_REJECT. ST_SCAN examines one element per cycle and moves to ST_FINISH after it examines the last counted element. ST_FINISH returns to ST_IDLE. ST_REJECT also returns to ST_IDLE.

Top module: `vcompress_unit`

## Requirements
- R1: For every source element index i below the element limit whose mask bit is 1, the element is written to the destination, in ascending i, at indices 0, 1, 2 and so on in turn.
- R2: Bit i of `mask_bits` selects source element i. An all-ones mask copies every counted element. An all-zeros mask writes no element.
- R3: After a legal run, every destination byte beyond the packed elements equals the corresponding byte of `old_dst`. This includes bytes beyond the register group.
- R4: The element limit is the smaller of `vl` and VLMAX. Elements at or above the limit are not examined, and their mask bits have no effect.
- R5: `sew_sel` values 0, 1, 2 and 3 select 8, 16, 32 and 64-bit elements. Element i occupies bytes i*SEW/8 upward, least significant byte first, in both the source and destination groups.
- R6: `lmul_sel` values 0, 1, 2 and 3 select groups of 1, 2, 4 and 8 registers. VLMAX is VLEN times the register count divided by SEW.
- R7: A start with a nonzero `vstart` is illegal.
- R8: A start is illegal if the destination register number or the source register number is not a multiple of the group register count.
- R9: A start is illegal if the destination group overlaps the source group, or if it contains the mask register. A mask register that lies inside the source group is legal.
- R10: For a legal start with element limit N, `done` is a one-cycle pulse, high in the cycle after the (N+1)-th rising edge counted from the edge that sampled `start`. With N = 0 it is high after the first such edge.
- R11: An illegal start raises `illegal` and `done` together for exactly one cycle after the first edge, and `dst_grp` keeps its previous value.
- R12: A `start` that arrives while a run is in progress, including its `done` cycle, is ignored.
- R13: Reset clears `dst_grp`, `done` and `illegal` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, sampled in ST_IDLE |
| vl | input | CNT_W | Requested element count |
| vstart | input | CNT_W | Starting element index; must be 0 |
| sew_sel | input | 2 | Element width code (R5) |
| lmul_sel | input | 2 | Group register count code (R6) |
| dst_reg | input | REG_W | Destination group base register number |
| src_reg | input | REG_W | Source group base register number |
| mask_reg | input | REG_W | Mask register number |
| src_grp | input | 8*VLEN | Source group contents |
| mask_bits | input | VLEN | Mask register contents |
| old_dst | input | 8*VLEN | Previous destination group contents |
| dst_grp | output | 8*VLEN | Resulting destination group |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Request rejected, valid with `done` |

## Verification
The hardest case to reach is a second `start` that lands while a scan is running. The stimulus raises `start` mid-run with a nonzero `vstart`, which would be rejected if it were accepted. The run must still finish on its original schedule, with no `illegal` and the original result. Other cases that random legal layouts seldom produce are built directly: a mask register inside the source group, a `vl` above VLMAX with a 64-bit element width, and a full 128-element group with 8-bit elements. Random runs then mix all widths and group sizes with random masks, and with an element count that sometimes exceeds VLMAX.

// File: rtl/vcu_pkg.sv
package vcu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_FINISH,
        ST_REJECT
    } vcu_state_e;

    // number of registers in a group for an LMUL code
    function automatic logic [3:0] regs_of(input logic [1:0] lmul_sel);
        return 4'd1 << lmul_sel;
    endfunction

    // bytes per element for a SEW code
    function automatic logic [3:0] bytes_of(input logic [1:0] sew_sel);
        return 4'd1 << sew_sel;
    endfunction

endpackage

// File: rtl/vcu_legal.sv
module vcu_legal #(
    parameter int REG_W = 5,
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] vstart,
    input  logic [1:0]       lmul_sel,
    input  logic [REG_W-1:0] dst_reg,
    input  logic [REG_W-1:0] src_reg,
    input  logic [REG_W-1:0] mask_reg,
    output logic             ok
);
    import vcu_pkg::*;

    localparam int AW = REG_W + 1;

    logic [AW-1:0] d, s, m, l;
    logic          d_al, s_al, ovl_src, ovl_msk;

    always_comb begin
        d       = AW'(dst_reg);
        s       = AW'(src_reg);
        m       = AW'(mask_reg);
        l       = AW'(regs_of(lmul_sel));
        d_al    = (d & (l - AW'(1))) == '0;
        s_al    = (s & (l - AW'(1))) == '0;
        ovl_src = (d < s + l) && (s < d + l);
        ovl_msk = (m >= d) && (m < d + l);
        ok      = (vstart == '0) && d_al && s_al && !ovl_src && !ovl_msk;
    end

endmodule

// File: rtl/vcu_ctrl.sv
module vcu_ctrl #(
    parameter int VLEN  = 128,
    parameter int CNT_W = 8,
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             ok,
    input  logic [CNT_W-1:0] vl,
    input  logic [1:0]       sew_sel,
    input  logic [1:0]       lmul_sel,
    input  logic [VLEN-1:0]  mask_bits,
    output logic             load,
    output logic             we,
    output logic [IDX_W-1:0] rptr,
    output logic [IDX_W-1:0] wptr,
    output logic             busy,
    output logic             done,
    output logic             illegal
);
    import vcu_pkg::*;

    vcu_state_e       state, nxt;
    logic [CNT_W-1:0] vlmax, limit, lim_q;
    logic [VLEN-1:0]  mask_q;
    logic             last;

    always_comb begin
        vlmax = (CNT_W'(VLEN / 8) << lmul_sel) >> sew_sel;
        limit = (vl > vlmax) ? vlmax : vl;
        last  = (CNT_W'(rptr) + CNT_W'(1)) == lim_q;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (!ok)                nxt = ST_REJECT;
                    else if (limit == '0)   nxt = ST_FINISH;
                    else                    nxt = ST_SCAN;
                end
            end
            ST_SCAN:   if (last) nxt = ST_FINISH;
            ST_FINISH: nxt = ST_IDLE;
            ST_REJECT: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // outputs
    always_comb begin
        load    = (state == ST_IDLE) && start && ok;
        we      = (state == ST_SCAN) && mask_q[rptr];
        busy    = (state != ST_IDLE);
        done    = (state == ST_FINISH) || (state == ST_REJECT);
        illegal = (state == ST_REJECT);
    end

    // read and write pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rptr   <= '0;
            wptr   <= '0;
            lim_q  <= '0;
            mask_q <= '0;
        end else if (load) begin
            rptr   <= '0;
            wptr   <= '0;
            lim_q  <= limit;
            mask_q <= mask_bits;
        end else if (state == ST_SCAN) begin
            rptr <= rptr + IDX_W'(1);
            if (mask_q[rptr]) wptr <= wptr + IDX_W'(1);
        end
    end

endmodule

// File: rtl/vcu_datapath.sv
module vcu_datapath #(
    parameter int VLEN  = 128,
    parameter int IDX_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              we,
    input  logic [IDX_W-1:0]  rptr,
    input  logic [IDX_W-1:0]  wptr,
    input  logic [1:0]        sew_sel,
    input  logic [8*VLEN-1:0] src_grp,
    input  logic [8*VLEN-1:0] old_dst,
    output logic [8*VLEN-1:0] dst_grp
);
    import vcu_pkg::*;

    localparam int GRP_BYTES = VLEN;
    localparam int BA_W      = $clog2(GRP_BYTES);
    localparam int AW        = IDX_W + 3;

    logic [7:0]    src_b [GRP_BYTES];
    logic [7:0]    dst_b [GRP_BYTES];
    logic [1:0]    sew_q;
    logic [AW-1:0] raddr [8];
    logic [AW-1:0] waddr [8];
    logic [7:0]    elem  [8];
    logic [7:0]    lane_wr;

    for (genvar b = 0; b < 8; b++) begin : g_lane
        assign raddr[b]   = (AW'(rptr) << sew_q) + AW'(b);
        assign waddr[b]   = (AW'(wptr) << sew_q) + AW'(b);
        assign elem[b]    = (raddr[b] < AW'(GRP_BYTES)) ? src_b[raddr[b][BA_W-1:0]] : 8'h00;
        assign lane_wr[b] = (4'(b) < bytes_of(sew_q)) && (waddr[b] < AW'(GRP_BYTES));
    end

    for (genvar i = 0; i < GRP_BYTES; i++) begin : g_out
        assign dst_grp[i*8 +: 8] = dst_b[i];
    end

    always_ff @(posedge clk) begin
        if (load) begin
            for (int i = 0; i < GRP_BYTES; i++) src_b[i] <= src_grp[i*8 +: 8];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sew_q <= '0;
            for (int i = 0; i < GRP_BYTES; i++) dst_b[i] <= '0;
        end else if (load) begin
            sew_q <= sew_sel;
            for (int i = 0; i < GRP_BYTES; i++) dst_b[i] <= old_dst[i*8 +: 8];
        end else if (we) begin
            for (int b = 0; b < 8; b++) begin
                if (lane_wr[b]) dst_b[waddr[b][BA_W-1:0]] <= elem[b];
            end
        end
    end

endmodule

// File: rtl/vcompress_unit.sv
module vcompress_unit #(
    parameter int VLEN = 128,
    parameter int NREG = 32,
    localparam int REG_W = $clog2(NREG),
    localparam int CNT_W = $clog2(VLEN + 1),
    localparam int GRP_W = 8 * VLEN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] vl,
    input  logic [CNT_W-1:0] vstart,
    input  logic [1:0]       sew_sel,
    input  logic [1:0]       lmul_sel,
    input  logic [REG_W-1:0] dst_reg,
    input  logic [REG_W-1:0] src_reg,
    input  logic [REG_W-1:0] mask_reg,
    input  logic [GRP_W-1:0] src_grp,
    input  logic [VLEN-1:0]  mask_bits,
    input  logic [GRP_W-1:0] old_dst,
    output logic [GRP_W-1:0] dst_grp,
    output logic             done,
    output logic             illegal
);
    localparam int IDX_W = $clog2(VLEN);

    logic             ok, load, we, busy;
    logic [IDX_W-1:0] rptr, wptr;

    vcu_legal #(.REG_W(REG_W), .CNT_W(CNT_W)) u_legal (
        .vstart   (vstart),
        .lmul_sel (lmul_sel),
        .dst_reg  (dst_reg),
        .src_reg  (src_reg),
        .mask_reg (mask_reg),
        .ok       (ok)
    );

    vcu_ctrl #(.VLEN(VLEN), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .ok        (ok),
        .vl        (vl),
        .sew_sel   (sew_sel),
        .lmul_sel  (lmul_sel),
        .mask_bits (mask_bits),
        .load      (load),
        .we        (we),
        .rptr      (rptr),
        .wptr      (wptr),
        .busy      (busy),
        .done      (done),
        .illegal   (illegal)
    );

    vcu_datapath #(.VLEN(VLEN), .IDX_W(IDX_W)) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .we      (we),
        .rptr    (rptr),
        .wptr    (wptr),
        .sew_sel (sew_sel),
        .src_grp (src_grp),
        .old_dst (old_dst),
        .dst_grp (dst_grp)
    );

endmodule

// File: rtl/vcu_checker.sv
module vcu_checker #(
    parameter int CNT_W = 8,
    parameter int IDX_W = 7,
    parameter int GRP_W = 1024
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             ok,
    input logic [CNT_W-1:0] vl,
    input logic [CNT_W-1:0] vstart,
    input logic             done,
    input logic             illegal,
    input logic [GRP_W-1:0] dst_grp,
    input logic [IDX_W-1:0] rptr,
    input logic [IDX_W-1:0] wptr
);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_EMPTY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && ok && vl == '0) |=> (done && !illegal)); // R10

    AST_ILLEGAL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> done); // R11

    AST_VSTART_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && vstart != '0) |=> illegal); // R7

    AST_REJECT_KEEPS_DST: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> $stable(dst_grp)); // R11

    AST_WPTR_BEHIND: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |-> (wptr <= rptr)); // R1

    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> !illegal); // R12

endmodule

bind vcompress_unit vcu_checker #(
    .CNT_W(CNT_W),
    .IDX_W(IDX_W),
    .GRP_W(GRP_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .ok      (ok),
    .vl      (vl),
    .vstart  (vstart),
    .done    (done),
    .illegal (illegal),
    .dst_grp (dst_grp),
    .rptr    (rptr),
    .wptr    (wptr)
);

// File: tb/tb_vcompress_unit.sv
module tb_vcompress_unit;

    localparam int VLEN  = 128;
    localparam int NREG  = 32;
    localparam int REG_W = $clog2(NREG);
    localparam int CNT_W = $clog2(VLEN + 1);
    localparam int GRP_W = 8 * VLEN;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [CNT_W-1:0] vl = '0;
    logic [CNT_W-1:0] vstart = '0;
    logic [1:0]       sew_sel = '0;
    logic [1:0]       lmul_sel = '0;
    logic [REG_W-1:0] dst_reg = '0;
    logic [REG_W-1:0] src_reg = '0;
    logic [REG_W-1:0] mask_reg = '0;
    logic [GRP_W-1:0] src_grp = '0;
    logic [VLEN-1:0]  mask_bits = '0;
    logic [GRP_W-1:0] old_dst = '0;
    logic [GRP_W-1:0] dst_grp;
    logic             done, illegal;

    int n_cmp = 0;
    int n_bad = 0;

    // requested configuration for the next run
    int               c_vl, c_vstart, c_sew, c_lmul, c_dst, c_src, c_msk;
    logic [GRP_W-1:0] c_srcg, c_old;
    logic [VLEN-1:0]  c_mask;

    always #5 clk = ~clk;

    vcompress_unit #(.VLEN(VLEN), .NREG(NREG)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .vstart(vstart),
        .sew_sel(sew_sel), .lmul_sel(lmul_sel), .dst_reg(dst_reg),
        .src_reg(src_reg), .mask_reg(mask_reg), .src_grp(src_grp),
        .mask_bits(mask_bits), .old_dst(old_dst), .dst_grp(dst_grp),
        .done(done), .illegal(illegal)
    );

    task automatic chk(input bit cond, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!cond) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_grp(input string req, input logic [GRP_W-1:0] exp);
        n_cmp++;
        if (dst_grp !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, dst_grp, exp);
        end
    endtask

    function automatic int vlmax_of(input int sew, input int lmul);
        return (VLEN / 8) * (1 << lmul) / (1 << sew);
    endfunction

    function automatic logic [GRP_W-1:0] rnd_grp();
        logic [GRP_W-1:0] g;
        for (int i = 0; i < GRP_W / 32; i++) g[i*32 +: 32] = $urandom;
        return g;
    endfunction

    function automatic logic [VLEN-1:0] rnd_mask();
        logic [VLEN-1:0] m;
        for (int i = 0; i < VLEN; i++) m[i] = 1'($urandom_range(0, 1));
        return m;
    endfunction

    task automatic run_case(input bit exp_ill, input bit poke, input string req);
        logic [GRP_W-1:0] exp;
        int lim, bsz, w, cnt, exp_lat;
        bsz = 1 << c_sew;
        lim = (c_vl > vlmax_of(c_sew, c_lmul)) ? vlmax_of(c_sew, c_lmul) : c_vl;
        if (exp_ill) begin
            exp     = dst_grp;
            exp_lat = 1;
        end else begin
            exp = c_old;
            w   = 0;
            for (int i = 0; i < lim; i++) begin
                if (c_mask[i]) begin
                    for (int b = 0; b < bsz; b++)
                        exp[(w*bsz+b)*8 +: 8] = c_srcg[(i*bsz+b)*8 +: 8];
                    w++;
                end
            end
            exp_lat = lim + 1;
        end
        @(negedge clk);
        vl        = CNT_W'(c_vl);
        vstart    = CNT_W'(c_vstart);
        sew_sel   = 2'(c_sew);
        lmul_sel  = 2'(c_lmul);
        dst_reg   = REG_W'(c_dst);
        src_reg   = REG_W'(c_src);
        mask_reg  = REG_W'(c_msk);
        src_grp   = c_srcg;
        mask_bits = c_mask;
        old_dst   = c_old;
        start     = 1'b1;
        @(negedge clk);
        cnt = 1;
        while (!done && cnt < 1000) begin
            if (poke && cnt == 2) begin
                start  = 1'b1;
                vstart = CNT_W'(3);
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cnt++;
        end
        start = 1'b0;
        if (cnt >= 1000) begin
            n_cmp++; n_bad++;
            $display("FAIL R10: actual timeout expected done");
        end
        chk(cnt == exp_lat, exp_ill ? "R11" : "R10", cnt, exp_lat);
        chk(illegal == exp_ill, exp_ill ? "R11" : "R12", illegal, exp_ill);
        chk_grp(req, exp);
        @(negedge clk);
        chk(!done && !illegal, "R10", done, 0);
    endtask

    task automatic legal_cfg();
        int l;
        c_lmul   = $urandom_range(0, 3);
        c_sew    = $urandom_range(0, 3);
        l        = 1 << c_lmul;
        c_vstart = 0;
        c_dst    = $urandom_range(0, NREG / l - 1) * l;
        do c_src = $urandom_range(0, NREG / l - 1) * l; while (c_src == c_dst);
        do c_msk = $urandom_range(0, NREG - 1); while (c_msk >= c_dst && c_msk < c_dst + l);
        c_vl     = $urandom_range(0, vlmax_of(c_sew, c_lmul) + 3);
        c_srcg   = rnd_grp();
        c_old    = rnd_grp();
        c_mask   = rnd_mask();
    endtask

    initial begin
        #2_000_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1bad5eed));
        repeat (3) @(negedge clk);
        chk(dst_grp == '0, "R13", 0, 0);
        chk(!done && !illegal, "R13", done, 0);
        rst_n = 1'b1;

        // R2 all-ones mask copies everything
        legal_cfg();
        c_sew = 0; c_lmul = 0; c_dst = 4; c_src = 8; c_msk = 0; c_vl = 16;
        c_mask = '1;
        run_case(0, 0, "R2");

        // R2 R3 all-zeros mask writes nothing
        legal_cfg();
        c_sew = 1; c_lmul = 1; c_dst = 2; c_src = 4; c_msk = 1; c_vl = 12;
        c_mask = '0;
        run_case(0, 0, "R3");

        // R10 empty run
        legal_cfg();
        c_vl = 0;
        run_case(0, 0, "R10");

        // R4 vl above VLMAX, 64-bit elements
        legal_cfg();
        c_sew = 3; c_lmul = 0; c_dst = 0; c_src = 1; c_msk = 2; c_vl = 10;
        c_mask = '1;
        run_case(0, 0, "R4");

        // R9 mask inside source group is legal
        legal_cfg();
        c_lmul = 1; c_dst = 0; c_src = 8; c_msk = 9; c_vl = 5;
        run_case(0, 0, "R9");

        // R6 full group of byte elements
        legal_cfg();
        c_sew = 0; c_lmul = 3; c_dst = 0; c_src = 8; c_msk = 16; c_vl = 128;
        run_case(0, 0, "R6");

        // R7 nonzero vstart
        legal_cfg();
        c_vstart = 1;
        run_case(1, 0, "R7");

        // R8 misaligned destination
        legal_cfg();
        c_lmul = 2; c_dst = 5; c_src = 16; c_msk = 0;
        run_case(1, 0, "R8");

        // R9 destination overlapping source
        legal_cfg();
        c_lmul = 1; c_dst = 4; c_src = 4; c_msk = 0;
        run_case(1, 0, "R9");

        // R9 mask register inside destination group
        legal_cfg();
        c_lmul = 2; c_dst = 8; c_src = 0; c_msk = 10;
        run_case(1, 0, "R9");

        // R12 start while busy is ignored
        legal_cfg();
        c_sew = 0; c_lmul = 0; c_dst = 2; c_src = 3; c_msk = 4; c_vl = 10;
        run_case(0, 1, "R12");

        // random mix of legal and illegal requests: R1 R5
        for (int k = 0; k < 60; k++) begin
            legal_cfg();
            if ($urandom_range(0, 4) == 0) begin
                c_vstart = $urandom_range(1, 7);
                run_case(1, 0, "R7");
            end else begin
                run_case(0, 0, "R1/R5");
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule